// File: doc/BRIEF.md
# Edge-Terminated Delay Measurement Timer

This timer measures how long it takes, after software arms it, for a chosen transition to appear on an external input. Arming loads the counter with a programmable start value. The counter then advances on a count tick, which comes either from the system clock divided by two or from an externally supplied prescaled tick. The external input first passes through a two-flop synchronizer.

When the selected transition arrives, the counter value is frozen into a capture register and the counter stops. A completion flag is raised, and an interrupt request follows if it is enabled. Software reads the captured value and subtracts the start value to get the elapsed tick count. A counter wrap sets an overflow flag, and the measurement continues after it. Only one capture happens per arming.

Software uses three register-style write strobes: one for control, one for the start value and one for clearing flags.

Top module: `edge_delay_timer`

## Requirements
- R1: After reset, `capture_value` is 0, `done_flag` and `ovf_flag` are 0 and `irq` is 0.
- R2: A control write (`ctrl_wr`) with `ctrl_wdata[0]`=1 while the enable bit is 0 arms the timer and loads the counter with the start value held in the preload register. A write with bit 0 = 1 while the timer is already enabled does not restart or re-arm it.
- R3: With `ctrl_wdata[3]`=0 the counter advances once every two clocks, with the first increment on the second clock after arming. With `ctrl_wdata[3]`=1 it advances on each clock in which `presc_tick` is 1.
- R4: `ctrl_wdata[1]`=0 selects a low-to-high transition of `ext_in` and 1 selects high-to-low, seen after a two-flop synchronizer. On that edge `capture_value` takes the counter value, so that (`capture_value` - start value) mod 2^24 equals the ticks elapsed since arming.
- R5: Only the first qualifying edge after arming is captured. Later edges leave `capture_value` unchanged until the timer is disabled and enabled again.
- R6: A capture sets `done_flag`. `irq` equals `done_flag` AND the interrupt-enable bit `ctrl_wdata[2]`.
- R7: While armed, the 24-bit counter wraps from 0xFFFFFF to 0 and sets `ovf_flag`. A later edge is still captured.
- R8: A `flag_clr_wr` with bit 0 set clears `done_flag` and with bit 1 set clears `ovf_flag`. A flag set in the same cycle wins over the clear.
- R9: A control write with bit 0 = 0 disarms the timer and stops the counter. `capture_value` is kept, and later edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control bits: [0] enable, [1] invert, [2] interrupt enable, [3] tick select |
| preload_wr | input | 1 | Start value write strobe |
| preload_wdata | input | 24 | Start value |
| flag_clr_wr | input | 1 | Flag clear strobe |
| flag_clr_wdata | input | 2 | Write-1-to-clear: [0] done, [1] overflow |
| presc_tick | input | 1 | Prescaled count tick, one clock wide |
| ext_in | input | 1 | Asynchronous external event input |
| capture_value | output | 24 | Counter value frozen at the terminating edge |
| done_flag | output | 1 | Capture has occurred |
| ovf_flag | output | 1 | Counter wrapped while armed |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a capture that follows a counter wrap, together with a flag clear landing in the same cycle as the capture. Reaching the wrap quickly needs a start value a few ticks below all ones. The bench then holds the done-clear strobe high over the whole window in which the synchronized edge can land. Its cycle-accurate reference model then confirms on every clock that the set wins and that the clear takes effect one cycle later.

// File: rtl/edt_pkg.sv
`timescale 1ns/1ps
package edt_pkg;

  typedef struct packed {
    logic tick_sel;   // [3] 0: clk/2, 1: prescaled tick
    logic irq_en;     // [2]
    logic invert;     // [1] 0: rising ends, 1: falling ends
    logic enable;     // [0]
  } edt_ctrl_t;

  function automatic logic edge_match(input logic now_v, input logic was_v,
                                      input logic invert);
    return invert ? (was_v & ~now_v) : (~was_v & now_v);
  endfunction

endpackage

// File: rtl/edt_edge_sync.sv
`timescale 1ns/1ps
module edt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_i,
  input  logic invert_i,
  output logic hit_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= ext_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign hit_o = edt_pkg::edge_match(chain_q[STAGES-1], last_q, invert_i);

  // R4: a hit requires the synchronized level to have changed since last cycle
  a_r4_hit_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> (last_q != $past(last_q)));
endmodule

// File: rtl/edt_tick_gen.sv
`timescale 1ns/1ps
module edt_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  input  logic sel_i,
  input  logic presc_i,
  output logic tick_o
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         phase_q <= 1'b0;
    else if (restart_i) phase_q <= 1'b0;
    else if (run_i)     phase_q <= ~phase_q;
  end

  assign tick_o = run_i & (sel_i ? presc_i : phase_q);

  // R3: the divide-by-two tick never fires on two consecutive clocks
  a_r3_div2_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !sel_i && tick_o) |=> (!tick_o || sel_i));
endmodule

// File: rtl/edt_capture_core.sv
`timescale 1ns/1ps
module edt_capture_core #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         disarm_i,
  input  logic         tick_i,
  input  logic         hit_i,
  input  logic [W-1:0] preload_i,
  input  logic         clr_done_i,
  input  logic         clr_ovf_i,
  output logic [W-1:0] capture_o,
  output logic         done_o,
  output logic         ovf_o,
  output logic         armed_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] step(input logic [W-1:0] c);
    return c + {{(W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic at_top(input logic [W-1:0] c);
    return c == TOP;
  endfunction

  logic [W-1:0] count_q;
  logic         armed_q;
  logic         capture_ev;
  logic         advance;
  logic         wrap_ev;

  assign capture_ev = armed_q & hit_i;
  assign advance    = armed_q & tick_i & ~hit_i;
  assign wrap_ev    = advance & at_top(count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      capture_o <= '0;
      armed_q   <= 1'b0;
      done_o    <= 1'b0;
      ovf_o     <= 1'b0;
    end else begin
      if (start_i)      count_q <= preload_i;
      else if (advance) count_q <= step(count_q);

      if (capture_ev) capture_o <= count_q;

      if (disarm_i)        armed_q <= 1'b0;
      else if (start_i)    armed_q <= 1'b1;
      else if (capture_ev) armed_q <= 1'b0;

      if (capture_ev)      done_o <= 1'b1;
      else if (clr_done_i) done_o <= 1'b0;

      if (wrap_ev)        ovf_o <= 1'b1;
      else if (clr_ovf_i) ovf_o <= 1'b0;
    end
  end

  assign armed_o = armed_q;

  a_r4_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && hit_i) |=> (capture_o == $past(count_q)));
  a_r5_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed_q && hit_i) |=> $stable(capture_o));
  a_r6_done_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && hit_i) |=> done_o);
  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && tick_i && !hit_i && count_q == TOP && !start_i) |=> (count_q == '0 && ovf_o));
  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !(armed_q && tick_i)) |=> $stable(count_q));
endmodule

// File: rtl/edge_delay_timer.sv
`timescale 1ns/1ps
module edge_delay_timer #(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [3:0]       ctrl_wdata,
  input  logic             preload_wr,
  input  logic [CNT_W-1:0] preload_wdata,
  input  logic             flag_clr_wr,
  input  logic [1:0]       flag_clr_wdata,
  input  logic             presc_tick,
  input  logic             ext_in,
  output logic [CNT_W-1:0] capture_value,
  output logic             done_flag,
  output logic             ovf_flag,
  output logic             irq
);
  import edt_pkg::*;

  edt_ctrl_t        ctrl_q;
  edt_ctrl_t        ctrl_in;
  logic [CNT_W-1:0] preload_q;
  logic             start;
  logic             disarm;
  logic             edge_hit;
  logic             tick;
  logic             armed;

  assign ctrl_in = edt_ctrl_t'(ctrl_wdata);
  assign start   = ctrl_wr & ctrl_in.enable & ~ctrl_q.enable;
  assign disarm  = ctrl_wr & ~ctrl_in.enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      preload_q <= '0;
    end else begin
      if (ctrl_wr)    ctrl_q    <= ctrl_in;
      if (preload_wr) preload_q <= preload_wdata;
    end
  end

  edt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ext_i(ext_in),
    .invert_i(ctrl_q.invert), .hit_o(edge_hit)
  );

  edt_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .restart_i(start), .run_i(armed),
    .sel_i(ctrl_q.tick_sel), .presc_i(presc_tick), .tick_o(tick)
  );

  edt_capture_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start_i(start), .disarm_i(disarm),
    .tick_i(tick), .hit_i(edge_hit), .preload_i(preload_q),
    .clr_done_i(flag_clr_wr & flag_clr_wdata[0]),
    .clr_ovf_i(flag_clr_wr & flag_clr_wdata[1]),
    .capture_o(capture_value), .done_o(done_flag), .ovf_o(ovf_flag),
    .armed_o(armed)
  );

  assign irq = done_flag & ctrl_q.irq_en;

  // R9: a disabling write always leaves the timer disarmed
  a_r9_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ctrl_wdata[0]) |=> !armed);
  // R2: a repeated enable write while enabled never arms an idle timer
  a_r2_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_q.enable && !armed) |=> !armed);
endmodule

// File: tb/sim_edge_delay_timer.sv
`timescale 1ns/1ps
module sim_edge_delay_timer;
  localparam int  W   = 24;
  localparam longint MAXV = (64'd1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_wr = 1'b0;
  logic [3:0] ctrl_wdata = '0;
  logic preload_wr = 1'b0;
  logic [W-1:0] preload_wdata = '0;
  logic flag_clr_wr = 1'b0;
  logic [1:0] flag_clr_wdata = '0;
  logic presc_tick = 1'b0;
  logic ext_in = 1'b0;
  logic [W-1:0] capture_value;
  logic done_flag, ovf_flag, irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int pc = 0;

  always #10 clk = ~clk;

  edge_delay_timer u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .preload_wr(preload_wr), .preload_wdata(preload_wdata),
    .flag_clr_wr(flag_clr_wr), .flag_clr_wdata(flag_clr_wdata),
    .presc_tick(presc_tick), .ext_in(ext_in),
    .capture_value(capture_value), .done_flag(done_flag),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  // ---------------- reference model ----------------
  bit     m_en, m_inv, m_ie, m_sel, m_armed, m_phase, m_done, m_ovf;
  longint m_cnt, m_pre, m_cap;
  int     m_ticks;
  bit     hist[$];

  task automatic model_reset();
    m_en = 0; m_inv = 0; m_ie = 0; m_sel = 0; m_armed = 0; m_phase = 0;
    m_done = 0; m_ovf = 0; m_cnt = 0; m_pre = 0; m_cap = 0; m_ticks = 0;
    hist = '{0, 0, 0};
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit cur, prv, hit, t, adv, st, dis;
      cur = hist[hist.size()-2];
      prv = hist[hist.size()-3];
      hit = m_armed && (m_inv ? (prv && !cur) : (!prv && cur));
      t   = m_armed && (m_sel ? presc_tick : m_phase);
      adv = t && !hit;
      st  = ctrl_wr && ctrl_wdata[0] && !m_en;
      dis = ctrl_wr && !ctrl_wdata[0];
      if (hit) begin m_cap = m_cnt; m_done = 1; end
      else if (flag_clr_wr && flag_clr_wdata[0]) m_done = 0;
      if (adv && m_cnt == MAXV) m_ovf = 1;
      else if (flag_clr_wr && flag_clr_wdata[1]) m_ovf = 0;
      if (st) begin m_cnt = m_pre; m_ticks = 0; end
      else if (adv) begin m_cnt = (m_cnt + 1) & MAXV; m_ticks++; end
      if (st) m_phase = 0; else if (m_armed) m_phase = !m_phase;
      if (dis) m_armed = 0; else if (st) m_armed = 1; else if (hit) m_armed = 0;
      if (ctrl_wr) begin
        m_en = ctrl_wdata[0]; m_inv = ctrl_wdata[1];
        m_ie = ctrl_wdata[2]; m_sel = ctrl_wdata[3];
      end
      if (preload_wr) m_pre = preload_wdata;
      hist.push_back(ext_in);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(capture_value == m_cap[W-1:0], "R4 capture_value", capture_value, m_cap);
      chk(done_flag == m_done, "R6 done_flag", done_flag, m_done);
      chk(ovf_flag == m_ovf, "R7 ovf_flag", ovf_flag, m_ovf);
      chk(irq == (m_done && m_ie), "R6 irq", irq, m_done && m_ie);
    end
  end

  always @(negedge clk) begin
    pc++;
    presc_tick = (pc % 3 == 0);
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr_ctrl(input logic [3:0] v);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 0;
  endtask
  task automatic wr_pre(input logic [W-1:0] v);
    @(negedge clk); preload_wr = 1; preload_wdata = v;
    @(negedge clk); preload_wr = 0;
  endtask
  task automatic clr(input logic [1:0] v);
    @(negedge clk); flag_clr_wr = 1; flag_clr_wdata = v;
    @(negedge clk); flag_clr_wr = 0;
  endtask
  task automatic set_ext(input logic v);
    @(negedge clk); ext_in = v;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    logic [W-1:0] held;
    idle(3);
    // R1 reset state
    chk(capture_value == 0, "R1 capture", capture_value, 0);
    chk(done_flag == 0 && ovf_flag == 0 && irq == 0, "R1 flags",
        {done_flag, ovf_flag, irq}, 0);
    @(negedge clk); rst_n = 1;
    idle(2);

    // R2 R3 R4: rising edge, clk/2 ticks, start value 100
    wr_pre(24'd100);
    wr_ctrl(4'b0001);
    idle(20);
    set_ext(1);
    idle(8);
    chk(done_flag == 1, "R6 done after rising edge", done_flag, 1);
    chk(((capture_value - 24'd100) & MAXV) == m_ticks, "R4 delay ticks",
        (capture_value - 24'd100) & MAXV, m_ticks);
    chk(m_ticks >= 10 && m_ticks <= 14, "R3 clk/2 rate", m_ticks, 12);
    chk(irq == 0, "R6 irq masked", irq, 0);

    // R5 later edges ignored
    held = capture_value;
    set_ext(0); idle(4); set_ext(1); idle(8);
    chk(capture_value == held, "R5 later edge ignored", capture_value, held);

    // R8 clear done
    clr(2'b01); idle(1);
    chk(done_flag == 0, "R8 done cleared", done_flag, 0);

    // R2 rewrite of enable while enabled does not re-arm
    wr_ctrl(4'b0001);
    set_ext(0); idle(4); set_ext(1); idle(8);
    chk(done_flag == 0, "R2 no rearm", done_flag, 0);
    chk(capture_value == held, "R2 capture kept", capture_value, held);

    // R4 R6 R3: falling edge, prescaled tick, irq enabled
    wr_ctrl(4'b0000);
    wr_pre(24'd5);
    idle(6);
    wr_ctrl(4'b1111);
    idle(30);
    set_ext(0);
    idle(8);
    chk(done_flag == 1 && irq == 1, "R6 irq raised", {done_flag, irq}, 3);
    chk(((capture_value - 24'd5) & MAXV) == m_ticks, "R3 prescaled ticks",
        (capture_value - 24'd5) & MAXV, m_ticks);
    chk(m_ticks >= 9 && m_ticks <= 12, "R3 prescale rate", m_ticks, 10);
    clr(2'b01);

    // R7 wrap then capture, R8 clear held across capture
    wr_ctrl(4'b0000);
    wr_pre(24'hFFFFF0);
    set_ext(0);
    idle(4);
    wr_ctrl(4'b0001);
    idle(50);
    chk(ovf_flag == 1, "R7 overflow set", ovf_flag, 1);
    chk(done_flag == 0, "R7 no capture yet", done_flag, 0);
    @(negedge clk); flag_clr_wr = 1; flag_clr_wdata = 2'b01; ext_in = 1;
    idle(10);
    flag_clr_wr = 0;
    idle(2);
    chk(done_flag == 0, "R8 clear after set", done_flag, 0);
    chk(((capture_value - 24'hFFFFF0) & MAXV) == m_ticks, "R7 capture after wrap",
        (capture_value - 24'hFFFFF0) & MAXV, m_ticks);
    chk(capture_value < 24'h100, "R7 wrapped value", capture_value, m_cap);
    clr(2'b10); idle(1);
    chk(ovf_flag == 0, "R8 ovf cleared", ovf_flag, 0);

    // R9 disable mid-measurement
    set_ext(0); idle(4);
    wr_ctrl(4'b0000); wr_pre(24'd7); wr_ctrl(4'b0001);
    idle(10);
    held = capture_value;
    wr_ctrl(4'b0000);
    idle(3);
    set_ext(1); idle(8);
    chk(done_flag == 0, "R9 edge ignored when disabled", done_flag, 0);
    chk(capture_value == held, "R9 capture kept", capture_value, held);

    idle(4);
    summary();
  end
endmodule